// File: doc/BRIEF.md
# Multi-Channel Phase-Offset Pulse Generator

This block drives a set of independent periodic pulse outputs from one clock. For every channel, software programs three 32-bit counts in clock cycles: the repetition period, the high time within each period and a start delay measured from a common restart point. Because every channel starts from the same point, the start delay fixes each channel's phase relative to its neighbours.

Software reaches the block through a simple word-addressed port with a write strobe and a read strobe. Configuration writes land in pending copies and do not reach the outputs straight away. A single load command moves all pending values of all channels into the running set together, so a new timing scheme never appears half applied. A run bit in the control word acts as an active-low soft reset for the timing logic. A fixed word tells software how many channels are present, and a free scratch word is provided for bus checks.

Top module: `ofs_pulse_gen`

## Requirements
- R1: After the hardware reset `rstN` is released, every pulse output is low and every register reads 0, except the channel-count word.
- R2: A write to byte address 0x08 stores a scratch word. Reads of that address return the last value written.
- R3: Byte address 0x14 is read-only and returns NUM_CH. Writes to it are ignored.
- R4: Bit 0 of the control word at 0x10 is the run bit and acts as an active-low soft reset. While it is 0, all outputs are low and all channel timing is held at its start point. Setting it to 1 restarts every channel, and the restart cycle is the first cycle in which the run bit reads 1.
- R5: Bit 1 of the control word is the load command. It is never stored, and reads of the control word always return 0 in bit 1.
- R6: For channel k, the period is held at 0x40+4k, the high time at 0x80+4k and the start delay at 0xC0+4k, for example 0x4C, 0x8C and 0xCC for k=3. Writes to these addresses go to pending copies that read back at once and leave the outputs unchanged.
- R7: Writing 1 to the load bit copies the pending values of every channel into the running set. The restart cycle is the second cycle after the write cycle. Relative to that restart cycle, channel k is high in cycle t when t >= offset and ((t - offset) mod period) < width.
- R8: A channel with period 0 keeps its output low.
- R9: A channel whose width is greater than or equal to its period stays high in every cycle from its offset onward.
- R10: A channel with width 0 keeps its output low.
- R11: Read data appears on `rdData` in the cycle after the one in which `rdEn` is high, and it holds between reads. Unmapped addresses, and channel addresses at or above NUM_CH, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| wrEn | input | 1 | Write strobe, one word per cycle |
| wrAddr | input | 8 | Byte address of the write |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | 8 | Byte address of the read |
| rdData | output | 32 | Registered read data |
| pulseOut | output | NUM_CH | One pulse output per channel |

## Verification
The assertions assume that a write and a read never target the control word in the same cycle. They also assume that the strobes and addresses are driven with known values from time zero, so that each past-cycle lookup sees a defined read or write. The bench drives only one access per cycle, and it drives each one between clock edges. Every period, width and offset it uses is small, so that each programmed pattern repeats several times within the checked windows.

// File: rtl/opg_pkg.sv
package opg_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 4;   // channel index bits, stride of 4 bytes in a 64-byte bank
  localparam logic [ADDR_W-1:0] A_SCRATCH = 8'h08;
  localparam logic [ADDR_W-1:0] A_CTRL    = 8'h10;
  localparam logic [ADDR_W-1:0] A_NCH     = 8'h14;
  localparam logic [1:0] BANK_PER = 2'd1;
  localparam logic [1:0] BANK_WID = 2'd2;
  localparam logic [1:0] BANK_OFS = 2'd3;

  typedef struct packed {
    logic run;      // level: timing enabled
    logic loadStb;  // one-cycle pulse: copy pending set into running set
  } opg_stb_t;
endpackage

// File: rtl/opg_ctrl.sv
module opg_ctrl
  import opg_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [DATA_W-1:0]             wrData,
  input  logic                          rdEn,
  input  logic [ADDR_W-1:0]             rdAddr,
  output logic [DATA_W-1:0]             rdData,
  output opg_stb_t                      stb,
  output logic [NUM_CH-1:0][CNT_W-1:0]  shPer,
  output logic [NUM_CH-1:0][CNT_W-1:0]  shWid,
  output logic [NUM_CH-1:0][CNT_W-1:0]  shOfs
);
  logic [DATA_W-1:0] scratch;
  logic              runBit;
  logic              loadPulse;
  logic [DATA_W-1:0] rdVal;

  logic [1:0]        wrBank, rdBank;
  logic [IDX_W-1:0]  wrIdx, rdIdx;
  logic              wrAligned, rdAligned;

  assign wrBank    = wrAddr[7:6];
  assign wrIdx     = wrAddr[5:2];
  assign wrAligned = (wrAddr[1:0] == 2'b00);
  assign rdBank    = rdAddr[7:6];
  assign rdIdx     = rdAddr[5:2];
  assign rdAligned = (rdAddr[1:0] == 2'b00);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scratch   <= '0;
      runBit    <= 1'b0;
      loadPulse <= 1'b0;
    end else begin
      loadPulse <= wrEn && (wrAddr == A_CTRL) && wrData[1];
      if (wrEn && wrAddr == A_SCRATCH) scratch <= wrData;
      if (wrEn && wrAddr == A_CTRL)    runBit  <= wrData[0];
    end
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_shadow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shPer[k] <= '0;
        shWid[k] <= '0;
        shOfs[k] <= '0;
      end else if (wrEn && wrAligned && wrIdx == IDX_W'(k)) begin
        if (wrBank == BANK_PER) shPer[k] <= wrData[CNT_W-1:0];
        if (wrBank == BANK_WID) shWid[k] <= wrData[CNT_W-1:0];
        if (wrBank == BANK_OFS) shOfs[k] <= wrData[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rdVal = '0;
    if (rdAddr == A_SCRATCH)  rdVal = scratch;
    else if (rdAddr == A_CTRL) rdVal = DATA_W'(runBit);
    else if (rdAddr == A_NCH)  rdVal = DATA_W'(NUM_CH);
    else if (rdAligned) begin
      for (int k = 0; k < NUM_CH; k++) begin
        if (rdIdx == IDX_W'(k)) begin
          if (rdBank == BANK_PER) rdVal = DATA_W'(shPer[k]);
          if (rdBank == BANK_WID) rdVal = DATA_W'(shWid[k]);
          if (rdBank == BANK_OFS) rdVal = DATA_W'(shOfs[k]);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdVal;
  end

  assign stb.run     = runBit;
  assign stb.loadStb = loadPulse;
endmodule

// File: rtl/opg_datapath.sv
module opg_datapath
  import opg_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  opg_stb_t                      stb,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  shPer,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  shWid,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  shOfs,
  output logic [NUM_CH-1:0]             pulseOut
);
  for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
    logic [CNT_W-1:0] actPer, actWid, actOfs, cnt;
    logic             inWait;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        actPer <= '0;
        actWid <= '0;
        actOfs <= '0;
        cnt    <= '0;
        inWait <= 1'b0;
      end else if (stb.loadStb) begin
        actPer <= shPer[k];
        actWid <= shWid[k];
        actOfs <= shOfs[k];
        cnt    <= '0;
        inWait <= (shOfs[k] != '0);
      end else if (!stb.run) begin
        cnt    <= '0;
        inWait <= (actOfs != '0);
      end else if (inWait) begin
        if (cnt == actOfs - 1'b1) begin
          cnt    <= '0;
          inWait <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (actPer == '0 || cnt == actPer - 1'b1) begin
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end

    assign pulseOut[k] = stb.run && !inWait && (actPer != '0) && (cnt < actWid);
  end
endmodule

// File: rtl/ofs_pulse_gen.sv
module ofs_pulse_gen
  import opg_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [7:0]        wrAddr,
  input  logic [31:0]       wrData,
  input  logic              rdEn,
  input  logic [7:0]        rdAddr,
  output logic [31:0]       rdData,
  output logic [NUM_CH-1:0] pulseOut
);
  opg_stb_t                     ctrlStb;
  logic [NUM_CH-1:0][CNT_W-1:0] shPer, shWid, shOfs;

  opg_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .stb(ctrlStb), .shPer(shPer), .shWid(shWid), .shOfs(shOfs)
  );

  opg_datapath #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(ctrlStb),
    .shPer(shPer), .shWid(shWid), .shOfs(shOfs),
    .pulseOut(pulseOut)
  );
endmodule

// File: rtl/opg_checks.sv
module opg_checks
  import opg_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [7:0]        wrAddr,
  input logic              rdEn,
  input logic [7:0]        rdAddr,
  input logic [31:0]       rdData,
  input logic [NUM_CH-1:0] pulseOut,
  input opg_stb_t          stb
);
  a_r4_held_low: assert property (@(posedge clk) disable iff (!rstN)
    !stb.run |-> pulseOut == '0);

  a_r5_load_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdEn && rdAddr == A_CTRL) |-> !rdData[1]);

  a_r3_count_read: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdEn && rdAddr == A_NCH) |-> rdData == 32'(NUM_CH));

  a_r7_load_from_write: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadStb |-> $past(wrEn && wrAddr == A_CTRL));

  a_r11_hold_between_reads: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rdEn) |-> $stable(rdData));
endmodule

bind ofs_pulse_gen opg_checks #(.NUM_CH(NUM_CH)) u_checks (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
  .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
  .pulseOut(pulseOut), .stb(ctrlStb)
);

// File: tb/test_ofs_pulse_gen.sv
module test_ofs_pulse_gen;
  localparam int NCH = 4;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            wrEn = 1'b0;
  logic [7:0]      wrAddr = '0;
  logic [31:0]     wrData = '0;
  logic            rdEn = 1'b0;
  logic [7:0]      rdAddr = '0;
  logic [31:0]     rdData;
  logic [NCH-1:0]  pulseOut;

  always #10 clk = ~clk;  // 50 MHz

  ofs_pulse_gen #(.NUM_CH(NCH)) i_ofs_pulse_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .pulseOut(pulseOut)
  );

  typedef struct {
    int          at;
    bit          isRead;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  int shP[NCH], shW[NCH], shO[NCH];
  int actP[NCH], actW[NCH], actO[NCH];
  int restartAt = 0;
  bit runOn = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] model(int at);
    logic [31:0] v = '0;
    for (int k = 0; k < NCH; k++) begin
      int t = at - restartAt;
      if (runOn && t >= actO[k] && actP[k] != 0)
        v[k] = (((t - actO[k]) % actP[k]) < actW[k]);
    end
    return v;
  endfunction

  function automatic void pushPulses(int first, int n, string tag);
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.at = first + i; it.isRead = 0; it.exp = model(first + i); it.tag = tag;
      q.push_back(it);
    end
  endfunction

  // Monitor: pops expected items as their cycle arrives
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = it.isRead ? rdData : 32'(pulseOut);
      checks++;
      if (it.at != cyc || act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h (cycle %0d, due %0d)",
                 it.tag, act, it.exp, cyc, it.at);
      end
    end
  end

  task automatic idle(int n, string tag);
    @(negedge clk);
    pushPulses(cyc + 1, n, tag);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, int nExp, string tag);
    int base, first;
    @(negedge clk);
    wrEn = 1; wrAddr = a; wrData = d;
    base = cyc + 1;
    first = base;
    if (a >= 8'h40 && a[1:0] == 2'b00) begin
      int k = int'(a[5:2]);
      if (k < NCH) begin
        if (a[7:6] == 2'd1) shP[k] = int'(d);
        if (a[7:6] == 2'd2) shW[k] = int'(d);
        if (a[7:6] == 2'd3) shO[k] = int'(d);
      end
    end
    if (a == 8'h10) begin
      if (d[1]) begin
        for (int k = 0; k < NCH; k++) begin
          actP[k] = shP[k]; actW[k] = shW[k]; actO[k] = shO[k];
        end
        restartAt = base + 1;
        first = base + 1;
      end else if (d[0] && !runOn) begin
        restartAt = base;
      end
      runOn = d[0];
    end
    pushPulses(first, nExp, tag);
    @(negedge clk);
    wrEn = 0;
    while (cyc < first + nExp) @(negedge clk);
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
    item_t it;
    @(negedge clk);
    rdEn = 1; rdAddr = a;
    it.at = cyc + 1; it.isRead = 1; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    rdEn = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NCH; k++) begin
      shP[k] = 0; shW[k] = 0; shO[k] = 0; actP[k] = 0; actW[k] = 0; actO[k] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    idle(3, "R1 outputs low after reset");
    rd(8'h10, 32'h0, "R1 control reads 0");
    rd(8'h40, 32'h0, "R1 period reads 0");
    rd(8'h08, 32'h0, "R1 scratch reads 0");
    // R2 scratch
    wr(8'h08, 32'hA5A5_1234, 0, "R2");
    rd(8'h08, 32'hA5A5_1234, "R2 scratch readback");
    // R3 count word, read-only
    rd(8'h14, NCH, "R3 channel count");
    wr(8'h14, 32'h7, 0, "R3");
    rd(8'h14, NCH, "R3 write ignored");
    // R6 pending config; ch2 period 0 (R8), ch3 width >= period (R9)
    wr(8'h40, 5, 2, "R6 outputs unchanged");
    wr(8'h80, 2, 0, "R6");
    wr(8'hC0, 0, 0, "R6");
    wr(8'h44, 4, 0, "R6");
    wr(8'h84, 1, 0, "R6");
    wr(8'hC4, 3, 0, "R6");
    wr(8'h48, 0, 0, "R6");
    wr(8'h88, 3, 0, "R6");
    wr(8'h4C, 3, 0, "R6");
    wr(8'h8C, 3, 0, "R6");
    wr(8'hCC, 2, 2, "R6 outputs unchanged");
    rd(8'h4C, 3, "R6 ch3 period readback");
    rd(8'h8C, 3, "R6 ch3 width readback");
    rd(8'hCC, 2, "R6 ch3 offset readback");
    rd(8'h50, 0, "R11 channel above NUM_CH reads 0");
    rd(8'h20, 0, "R11 unmapped reads 0");
    // R5 load while held; R4 outputs stay low
    wr(8'h10, 32'h2, 8, "R4 held low after load");
    rd(8'h10, 32'h0, "R5 load bit reads 0");
    // R4 release: restart, R7/R8/R9 patterns
    wr(8'h10, 32'h1, 24, "R7 R8 R9 pattern after release");
    rd(8'h10, 32'h1, "R5 control reads run only");
    // R6 isolation while running: ch0 width 4, ch1 width 0 (R10) pending
    wr(8'h80, 4, 0, "R6");
    wr(8'h84, 0, 12, "R6 running set unchanged before load");
    // R7 load while running
    wr(8'h10, 32'h3, 24, "R7 R10 pattern after load");
    // R4 soft reset then restart
    wr(8'h10, 32'h0, 6, "R4 soft reset drives low");
    wr(8'h10, 32'h1, 16, "R4 restart after soft reset");
    rd(8'h80, 4, "R6 ch0 width readback");
    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule